// File: doc/BRIEF.md
# Host/Controller Mailbox with Status Flags

This block is a byte-wide mailbox between an external host and a local controller. The host writes bytes into an inbound register and reads bytes from an outbound register. The controller does the reverse. A shared 8-bit status register tells each side whether a byte is waiting. It also records whether the last inbound byte was a command or plain data, and it holds five general-purpose flags that only the controller can write.

The host port is a minimal I/O interface: one address bit (`h_a2`), single-cycle read and write strobes, and byte data.
- A host write with `h_a2 = 0` deposits a data byte.
- A host write with `h_a2 = 1` deposits a command byte.
- A host read with `h_a2 = 0` returns the outbound byte.
- A host read with `h_a2 = 1` returns the status register.

The controller reaches four registers through a 2-bit address: the inbound byte, the outbound byte, the status register and a control register. The control register holds an interrupt enable. The interrupt line toward the controller follows the inbound-full flag whenever that enable is set.

Top module: `mbox_status`

## Requirements
- R1: After reset, all eight status bits, both data registers and the interrupt enable are 0, and `irq` is low.
- R2: A controller write to address 1 loads the outbound byte and sets status bit 0 (outbound full). A host read with `h_a2 = 0` returns that byte.
- R3: A host read with `h_a2 = 0` clears status bit 0 at the clock edge that ends the read.
- R4: A controller write to the status register (address 2) with data bit 0 = 0 clears status bit 0. The same write with data bit 0 = 1 leaves status bit 0 unchanged.
- R5: A host write sets status bit 1 (inbound full) and loads the inbound byte, which the controller reads at address 0. A controller read of address 0 clears status bit 1.
- R6: On every host write, status bit 3 captures `h_a2` (0 = data, 1 = command). The bit keeps its value until the next host write.
- R7: Controller writes to address 2 load status bits 7..4 and bit 2 from the matching data bits. Those writes never change bits 1 and 3.
- R8: A host read with `h_a2 = 1` returns the status register and changes no flag. The host port has no path that alters bits 7..4, bit 2 or bit 0.
- R9: When a set event and a clear event hit the same flag in one clock cycle, the flag ends up set.
- R10: Control register bit 0 (address 3, readable) is the interrupt enable. `irq` is high exactly when that bit and status bit 1 are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_a2 | input | 1 | Host address bit: 0 = data, 1 = command/status |
| h_rd | input | 1 | Host read strobe, one cycle per access |
| h_wr | input | 1 | Host write strobe, one cycle per access |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data (outbound byte or status) |
| c_addr | input | 2 | Controller address: 0 inbound, 1 outbound, 2 status, 3 control |
| c_rd | input | 1 | Controller read strobe |
| c_wr | input | 1 | Controller write strobe |
| c_wdata | input | 8 | Controller write data |
| c_rdata | output | 8 | Controller read data |
| irq | output | 1 | Interrupt request to the controller |

## Verification
Every flag is a single register bit updated at the edge that ends an access. A wrong set, clear or capture therefore shows up in the very next status read from either side, one cycle later. A lost set under a same-cycle collision shows up the same way, as a 0 where a 1 belongs. A wrong interrupt enable or inbound flag appears on `irq` within the same cycle.

// File: rtl/mbox_status.sv
module mbox_status #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_a2,
  input  logic          h_rd,
  input  logic          h_wr,
  input  logic [DW-1:0] h_wdata,
  output logic [DW-1:0] h_rdata,
  input  logic [1:0]    c_addr,
  input  logic          c_rd,
  input  logic          c_wr,
  input  logic [DW-1:0] c_wdata,
  output logic [DW-1:0] c_rdata,
  output logic          irq
);
  localparam logic [1:0] A_IN   = 2'd0;
  localparam logic [1:0] A_OUT  = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;
  localparam logic [1:0] A_CTRL = 2'd3;

  logic [DW-1:0] inb_q, outb_q;
  logic          ibf_q, obf_q, cmd_q, ien_q;
  logic [4:0]    gp_q;
  logic [7:0]    status;

  wire c_wr_out  = c_wr && c_addr == A_OUT;
  wire c_wr_stat = c_wr && c_addr == A_STAT;
  wire c_wr_ctrl = c_wr && c_addr == A_CTRL;
  wire c_rd_in   = c_rd && c_addr == A_IN;
  wire h_rd_out  = h_rd && !h_a2;

  wire obf_set = c_wr_out;
  wire obf_clr = h_rd_out || (c_wr_stat && !c_wdata[0]);
  wire ibf_set = h_wr;
  wire ibf_clr = c_rd_in;

  assign status = {gp_q[4:1], cmd_q, gp_q[0], ibf_q, obf_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inb_q  <= '0;
      outb_q <= '0;
      ibf_q  <= 1'b0;
      obf_q  <= 1'b0;
      cmd_q  <= 1'b0;
      ien_q  <= 1'b0;
      gp_q   <= '0;
    end else begin
      if (h_wr) begin
        inb_q <= h_wdata;
        cmd_q <= h_a2;
      end
      if (c_wr_out)  outb_q <= c_wdata;
      if (c_wr_stat) gp_q   <= {c_wdata[7:4], c_wdata[2]};
      if (c_wr_ctrl) ien_q  <= c_wdata[0];
      ibf_q <= ibf_set || (ibf_q && !ibf_clr);
      obf_q <= obf_set || (obf_q && !obf_clr);
    end
  end

  assign h_rdata = h_a2 ? DW'(status) : outb_q;

  always_comb begin
    case (c_addr)
      A_IN:    c_rdata = inb_q;
      A_OUT:   c_rdata = outb_q;
      A_STAT:  c_rdata = DW'(status);
      default: c_rdata = DW'(ien_q);
    endcase
  end

  assign irq = ibf_q && ien_q;

  assert_obf_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    c_wr_out |=> (status[0] && outb_q == $past(c_wdata)));

  assert_obf_hclr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (h_rd_out && !c_wr_out) |=> !status[0]);

  assert_obf_w1_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (c_wr_stat && c_wdata[0] && !h_rd) |=> status[0] == $past(status[0]));

  assert_ibf_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    h_wr |=> status[1]);

  assert_cmd_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    h_wr |=> status[3] == $past(h_a2));

  assert_ro_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (c_wr_stat && !h_wr && !c_rd) |=> (status[1] == $past(status[1]) && status[3] == $past(status[3])));

  assert_stat_rd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (h_rd && h_a2 && !h_wr && !c_wr && !c_rd) |=> $stable(status));

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (c_wr_out && h_rd_out) |=> status[0]);

  assert_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && ien_q && !c_wr_ctrl) |=> irq);
endmodule

// File: tb/sim_mbox_status.sv
`timescale 1ns/1ps
module sim_mbox_status;
  logic clk = 1'b0, rst_n = 1'b0;
  logic h_a2 = 1'b0, h_rd = 1'b0, h_wr = 1'b0;
  logic [7:0] h_wdata = '0, c_wdata = '0;
  logic [1:0] c_addr = '0;
  logic c_rd = 1'b0, c_wr = 1'b0;
  logic [7:0] h_rdata, c_rdata;
  logic irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mbox_status u0 (.clk(clk), .rst_n(rst_n), .h_a2(h_a2), .h_rd(h_rd), .h_wr(h_wr),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .c_addr(c_addr), .c_rd(c_rd), .c_wr(c_wr),
    .c_wdata(c_wdata), .c_rdata(c_rdata), .irq(irq));

  // op: 0 host write, 1 host read, 2 ctrl write, 3 ctrl read, 4 irq check
  localparam int NV = 36;
  localparam logic [20:0] VEC [NV] = '{
    {3'd1,2'd1,8'h00,8'h00}, {3'd3,2'd2,8'h00,8'h00}, {3'd3,2'd3,8'h00,8'h00},
    {3'd2,2'd1,8'hA5,8'h00}, {3'd1,2'd1,8'h00,8'h01}, {3'd1,2'd0,8'h00,8'hA5},
    {3'd1,2'd1,8'h00,8'h00}, {3'd2,2'd1,8'h3C,8'h00}, {3'd2,2'd2,8'h01,8'h00},
    {3'd3,2'd2,8'h00,8'h01}, {3'd2,2'd2,8'h00,8'h00}, {3'd1,2'd1,8'h00,8'h00},
    {3'd0,2'd0,8'h5A,8'h00}, {3'd1,2'd1,8'h00,8'h02}, {3'd3,2'd0,8'h00,8'h5A},
    {3'd1,2'd1,8'h00,8'h00}, {3'd0,2'd1,8'h99,8'h00}, {3'd1,2'd1,8'h00,8'h0A},
    {3'd3,2'd0,8'h00,8'h99}, {3'd1,2'd1,8'h00,8'h08}, {3'd0,2'd0,8'h11,8'h00},
    {3'd3,2'd2,8'h00,8'h02}, {3'd3,2'd0,8'h00,8'h11}, {3'd2,2'd2,8'hFF,8'h00},
    {3'd1,2'd1,8'h00,8'hF4}, {3'd2,2'd2,8'h0A,8'h00}, {3'd1,2'd1,8'h00,8'h00},
    {3'd0,2'd0,8'h77,8'h00}, {3'd2,2'd3,8'h01,8'h00}, {3'd4,2'd0,8'h00,8'h01},
    {3'd2,2'd3,8'h00,8'h00}, {3'd4,2'd0,8'h00,8'h00}, {3'd2,2'd3,8'h01,8'h00},
    {3'd3,2'd0,8'h00,8'h77}, {3'd4,2'd0,8'h00,8'h00}, {3'd3,2'd3,8'h00,8'h01}
  };
  localparam string TAG [NV] = '{
    "R1","R1","R1","R2","R2","R2","R3","R2","R4","R4","R4","R4",
    "R5","R5","R5","R5","R6","R6","R5","R6","R6","R6","R5","R7",
    "R7","R7","R7","R5","R10","R10","R10","R10","R10","R10","R10","R10"};

  task automatic check(input string rq, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", rq, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    h_rd = 0; h_wr = 0; c_rd = 0; c_wr = 0;
  endtask

  task automatic do_op(input logic [2:0] op, input logic [1:0] a, input logic [7:0] d,
                       input logic [7:0] e, input string rq);
    @(negedge clk);
    case (op)
      3'd0: begin h_a2 = a[0]; h_wdata = d; h_wr = 1; end
      3'd1: begin h_a2 = a[0]; h_rd = 1; #1 check(rq, h_rdata, e); end
      3'd2: begin c_addr = a; c_wdata = d; c_wr = 1; end
      3'd3: begin c_addr = a; c_rd = 1; #1 check(rq, c_rdata, e); end
      default: begin #1 check(rq, {7'd0, irq}, e); end
    endcase
    idle();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {7'd0, irq}, 8'h00);
    rst_n = 1;
    for (int i = 0; i < NV; i++)
      do_op(VEC[i][20:18], VEC[i][17:16], VEC[i][15:8], VEC[i][7:0], TAG[i]);

    // R9: host read of outbound and controller write of outbound in one cycle
    do_op(3'd2, 2'd1, 8'h42, 8'h00, "R9");
    @(negedge clk);
    h_a2 = 0; h_rd = 1; c_addr = 2'd1; c_wdata = 8'h43; c_wr = 1;
    idle();
    do_op(3'd1, 2'd1, 8'h00, 8'h01, "R9");
    do_op(3'd1, 2'd0, 8'h00, 8'h43, "R9");
    // R9: host write and controller inbound read in one cycle
    do_op(3'd0, 2'd0, 8'h21, 8'h00, "R9");
    @(negedge clk);
    h_a2 = 1; h_wdata = 8'h22; h_wr = 1; c_addr = 2'd0; c_rd = 1;
    #1 check("R9", c_rdata, 8'h21);
    idle();
    do_op(3'd1, 2'd1, 8'h00, 8'h0A, "R9");
    // R8: repeated status reads leave both full flags and user bits intact
    do_op(3'd2, 2'd2, 8'hA4, 8'h00, "R8");
    do_op(3'd2, 2'd1, 8'h55, 8'h00, "R8");
    do_op(3'd1, 2'd1, 8'h00, 8'hAF, "R8");
    do_op(3'd1, 2'd1, 8'h00, 8'hAF, "R8");
    do_op(3'd3, 2'd2, 8'h00, 8'hAF, "R8");
    // R8: host writes do not touch user bits or the outbound flag
    do_op(3'd0, 2'd0, 8'hFF, 8'h00, "R8");
    do_op(3'd1, 2'd1, 8'h00, 8'hA7, "R8");
    // R4: writing 1 to bit 0 while empty does not set it
    do_op(3'd1, 2'd0, 8'h00, 8'h55, "R3");
    do_op(3'd2, 2'd2, 8'h01, 8'h00, "R4");
    do_op(3'd1, 2'd1, 8'h00, 8'h02, "R4");
    // R1: reset mid-operation
    do_op(3'd2, 2'd3, 8'h01, 8'h00, "R1");
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    check("R1", {7'd0, irq}, 8'h00);
    rst_n = 1;
    do_op(3'd1, 2'd1, 8'h00, 8'h00, "R1");
    do_op(3'd3, 2'd3, 8'h00, 8'h00, "R1");
    do_op(3'd3, 2'd0, 8'h00, 8'h00, "R1");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule